// File: doc/BRIEF.md
# Three-Level Sub-Hexagon Decomposer with Capacitor Balancing

This block turns a three-phase reference for a neutral-point-clamped three-level converter into a plain two-level problem. Once per switching period, on a strobe, it picks one of six two-level sub-hexagons from the signs of the three references. For every leg it fixes one switch from that sub-hexagon's central vector. It also subtracts the central-vector voltages from the references, which leaves the two-level references that a downstream two-level modulator works on.

The same strobe splits the zero-vector time supplied by that two-level modulator between the positive and the negative redundant small vectors. The split follows a signed coefficient f. In hysteresis mode f is a hard plus or minus one, taken from which of the two DC-link capacitors holds more voltage. In PI mode f comes from a proportional-integral controller acting on the capacitor voltage difference. It is clamped to the range -1 to +1, and its integrator stops accumulating while the output sits at a clamp.

Coefficients are fixed point with FRAC fractional bits (default 12, so ONE = 4096). All results are captured at the rising edge on which `periodStb` is high.

Top module: `npc_balancer`

## Requirements
- R1: While `rstN` is low and after its release, until the first strobe, every output is zero and the integrator state is zero.
- R2: Outputs change only at a rising edge where `periodStb` is 1. At that edge they take the values computed from the inputs present at that edge. With the strobe low, the outputs hold whatever the inputs do.
- R3: Sub-hexagons 1..6 have the central vectors 100, 110, 010, 011, 001 and 101, with bit 2 = phase A, bit 1 = B and bit 0 = C. Sub-hexagon n matches when every phase whose bit is 1 has a reference >= 0 and every phase whose bit is 0 has a reference <= 0. The lowest matching n is reported on `subHex`, and its vector on `centralVec`. If no n matches, sub-hexagon 1 is reported.
- R4: Per leg (same bit order), `holdInnerOn` equals the central-vector bit: the inner-upper switch is forced on. `holdOuterOff` equals its inverse: the outer-upper switch is forced off.
- R5: With D = floor((vUp+vLo)/6), take the phase whose bit differs from the other two. Its central voltage is +2D if that bit is 1 and -2D if it is 0. The other two phases get -D or +D respectively. Each reduced reference equals the phase reference minus its central voltage.
- R6: `tPos` = floor((ONE+f)·tz / (2·ONE)) and `tNeg` = tz − `tPos`, using the f computed at the same strobe.
- R7: In hysteresis mode (`hystMode`=1), f = +ONE when vUp > vLo, −ONE when vUp < vLo, and 0 when they are equal.
- R8: In PI mode, with e = vUp − vLo, f = clamp(kp·e + I + ki·e, −ONE, +ONE), where I is the integrator state.
- R9: The integrator takes I + ki·e only at a strobe in PI mode whose unclamped sum lies inside ±ONE. In every other case, including hysteresis mode, it holds.
- R10: `coefF` always lies within −ONE..+ONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodStb | input | 1 | One-cycle strobe per switching period |
| hystMode | input | 1 | 1 = hysteresis coefficient, 0 = PI coefficient |
| refA | input | W | Signed phase A reference |
| refB | input | W | Signed phase B reference |
| refC | input | W | Signed phase C reference |
| vUp | input | VW | Upper capacitor voltage, unsigned |
| vLo | input | VW | Lower capacitor voltage, unsigned |
| tzIn | input | TW | Two-level zero-vector time |
| kp | input | CW | Signed proportional gain, FRAC fraction bits |
| ki | input | CW | Signed integral gain per period, FRAC fraction bits |
| subHex | output | 3 | Selected sub-hexagon 1..6 (0 before first strobe) |
| centralVec | output | 3 | Central vector of the sub-hexagon |
| holdInnerOn | output | 3 | Legs whose inner-upper switch is forced on |
| holdOuterOff | output | 3 | Legs whose outer-upper switch is forced off |
| redA | output | RW | Signed reduced reference, phase A |
| redB | output | RW | Signed reduced reference, phase B |
| redC | output | RW | Signed reduced reference, phase C |
| tPos | output | TW | Positive small-vector time |
| tNeg | output | TW | Negative small-vector time |
| coefF | output | FRAC+2 | Signed balancing coefficient f |

## Verification
Full-range random references visit all six sign sectors. Directed references with one or all phases at exactly zero separate the lowest-number tie rule from a mere sign decode. Capacitor pairs that are equal, slightly apart and widely apart tell the zero, plus and minus hysteresis outcomes apart, and in PI mode they separate the clamped case from the linear one. A gain step that saturates f, followed by a zero proportional gain, exposes whether the integrator kept accumulating during saturation. Changing inputs with the strobe low shows that nothing moves between periods.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef struct packed {
    logic capture;
    logic integUpd;
    logic hyst;
  } npcCtrl_t;

  function automatic logic [2:0] cvOf(input int hexIdx);
    case (hexIdx)
      1:       cvOf = 3'b100;
      2:       cvOf = 3'b110;
      3:       cvOf = 3'b010;
      4:       cvOf = 3'b011;
      5:       cvOf = 3'b001;
      default: cvOf = 3'b101;
    endcase
  endfunction

endpackage

// File: rtl/npc_subhex_sel.sv
module npc_subhex_sel #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] refA,
  input  logic signed [W-1:0] refB,
  input  logic signed [W-1:0] refC,
  output logic [2:0]          hexNum,
  output logic [2:0]          cvSel
);
  import npc_pkg::*;

  localparam int NHEX = 6;

  logic signed [W-1:0] legRef [3];
  logic [NHEX-1:0]     match;

  always_comb begin
    legRef[2] = refA;
    legRef[1] = refB;
    legRef[0] = refC;
  end

  for (genvar g = 0; g < NHEX; g++) begin : g_hex
    localparam logic [2:0] CV = cvOf(g + 1);
    logic [2:0] legOk;
    always_comb begin
      for (int l = 0; l < 3; l++) begin
        if (CV[l]) legOk[l] = !legRef[l][W-1];
        else       legOk[l] = legRef[l][W-1] || (legRef[l] == '0);
      end
    end
    assign match[g] = &legOk;
  end

  always_comb begin
    hexNum = 3'd1;
    cvSel  = cvOf(1);
    for (int i = NHEX - 1; i >= 0; i--) begin
      if (match[i]) begin
        hexNum = 3'(i + 1);
        cvSel  = cvOf(i + 1);
      end
    end
  end

endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl (
  input  logic              periodStb,
  input  logic              hystMode,
  input  logic              satNow,
  output npc_pkg::npcCtrl_t ctl
);
  always_comb begin
    ctl.capture  = periodStb;
    ctl.hyst     = hystMode;
    ctl.integUpd = periodStb && !hystMode && !satNow;
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath #(
  parameter int W    = 16,
  parameter int VW   = 16,
  parameter int TW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  npc_pkg::npcCtrl_t       ctl,
  input  logic signed [W-1:0]     refA,
  input  logic signed [W-1:0]     refB,
  input  logic signed [W-1:0]     refC,
  input  logic [VW-1:0]           vUp,
  input  logic [VW-1:0]           vLo,
  input  logic [TW-1:0]           tzIn,
  input  logic signed [CW-1:0]    kp,
  input  logic signed [CW-1:0]    ki,
  output logic                    satNow,
  output logic [2:0]              subHex,
  output logic [2:0]              centralVec,
  output logic [2:0]              holdInnerOn,
  output logic [2:0]              holdOuterOff,
  output logic signed [((W > VW) ? W : VW)+1:0] redA,
  output logic signed [((W > VW) ? W : VW)+1:0] redB,
  output logic signed [((W > VW) ? W : VW)+1:0] redC,
  output logic [TW-1:0]           tPos,
  output logic [TW-1:0]           tNeg,
  output logic signed [FRAC+1:0]  coefF
);
  localparam int RW = ((W > VW) ? W : VW) + 2;
  localparam int EW = VW + 1;
  localparam int PW = CW + EW;
  localparam int AW = PW + 8;
  localparam int FW = FRAC + 2;
  localparam logic signed [FW-1:0] ONE_F = {2'b01, {FRAC{1'b0}}};
  localparam logic signed [AW-1:0] ONE_A = {{(AW-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

  // sector and central vector
  logic [2:0] hexN, cvN;
  npc_subhex_sel #(.W(W)) u_sel (
    .refA(refA), .refB(refB), .refC(refC), .hexNum(hexN), .cvSel(cvN)
  );

  // balancing coefficient
  logic signed [EW-1:0] err;
  logic signed [PW-1:0] pTerm, iTerm;
  logic signed [AW-1:0] integQ, iNext, fRaw;
  logic signed [FW-1:0] hystF, fNext;
  logic satHi, satLo;

  assign err   = $signed({1'b0, vUp}) - $signed({1'b0, vLo});
  assign pTerm = kp * err;
  assign iTerm = ki * err;
  assign iNext = integQ + $signed({{(AW-PW){iTerm[PW-1]}}, iTerm});
  assign fRaw  = iNext + $signed({{(AW-PW){pTerm[PW-1]}}, pTerm});
  assign satHi = fRaw > ONE_A;
  assign satLo = fRaw < -ONE_A;
  assign satNow = satHi || satLo;

  always_comb begin
    if (vUp > vLo)      hystF = ONE_F;
    else if (vUp < vLo) hystF = -ONE_F;
    else                hystF = '0;
    if (ctl.hyst)  fNext = hystF;
    else if (satHi) fNext = ONE_F;
    else if (satLo) fNext = -ONE_F;
    else            fNext = fRaw[FW-1:0];
  end

  // small-vector split
  logic [FW:0]     fSum;
  logic [FW+TW:0]  prod;
  logic [TW-1:0]   tPosN;
  assign fSum  = {fNext[FW-1], fNext} + {1'b0, ONE_F};
  assign prod  = fSum * tzIn;
  assign tPosN = prod[TW+FRAC:FRAC+1];

  // central voltages and reduced references
  logic [VW:0]          vSum, dUnit;
  logic signed [RW-1:0] dS, d2;
  logic signed [W-1:0]  legRef [3];
  logic signed [RW-1:0] redN [3];
  logic                 singleHigh;

  assign vSum  = {1'b0, vUp} + {1'b0, vLo};
  assign dUnit = vSum / (VW+1)'(6);
  assign dS    = $signed({{(RW-VW-1){1'b0}}, dUnit});
  assign d2    = dS <<< 1;
  assign singleHigh = ($countones(cvN) == 1);

  always_comb begin
    legRef[2] = refA;
    legRef[1] = refB;
    legRef[0] = refC;
  end

  for (genvar g = 0; g < 3; g++) begin : g_leg
    logic signed [RW-1:0] refExt, cenV;
    assign refExt = $signed({{(RW-W){legRef[g][W-1]}}, legRef[g]});
    always_comb begin
      if (singleHigh) cenV = cvN[g] ? d2 : -dS;
      else            cenV = cvN[g] ? dS : -d2;
    end
    assign redN[g] = refExt - cenV;
  end

  // registers
  logic [2:0]           hexQ, cvQ;
  logic signed [RW-1:0] redQ [3];
  logic [TW-1:0]        tPosQ, tNegQ;
  logic signed [FW-1:0] fQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hexQ   <= '0;
      cvQ    <= '0;
      redQ   <= '{default: '0};
      tPosQ  <= '0;
      tNegQ  <= '0;
      fQ     <= '0;
      integQ <= '0;
    end else begin
      if (ctl.capture) begin
        hexQ  <= hexN;
        cvQ   <= cvN;
        redQ  <= redN;
        tPosQ <= tPosN;
        tNegQ <= tzIn - tPosN;
        fQ    <= fNext;
      end
      if (ctl.integUpd) integQ <= iNext;
    end
  end

  assign subHex       = hexQ;
  assign centralVec   = cvQ;
  assign holdInnerOn  = cvQ;
  assign holdOuterOff = (hexQ != '0) ? ~cvQ : 3'b000;
  assign redA  = redQ[2];
  assign redB  = redQ[1];
  assign redC  = redQ[0];
  assign tPos  = tPosQ;
  assign tNeg  = tNegQ;
  assign coefF = fQ;

endmodule

// File: rtl/npc_balancer.sv
module npc_balancer #(
  parameter int W    = 16,
  parameter int VW   = 16,
  parameter int TW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    periodStb,
  input  logic                    hystMode,
  input  logic signed [W-1:0]     refA,
  input  logic signed [W-1:0]     refB,
  input  logic signed [W-1:0]     refC,
  input  logic [VW-1:0]           vUp,
  input  logic [VW-1:0]           vLo,
  input  logic [TW-1:0]           tzIn,
  input  logic signed [CW-1:0]    kp,
  input  logic signed [CW-1:0]    ki,
  output logic [2:0]              subHex,
  output logic [2:0]              centralVec,
  output logic [2:0]              holdInnerOn,
  output logic [2:0]              holdOuterOff,
  output logic signed [((W > VW) ? W : VW)+1:0] redA,
  output logic signed [((W > VW) ? W : VW)+1:0] redB,
  output logic signed [((W > VW) ? W : VW)+1:0] redC,
  output logic [TW-1:0]           tPos,
  output logic [TW-1:0]           tNeg,
  output logic signed [FRAC+1:0]  coefF
);
  npc_pkg::npcCtrl_t ctl;
  logic satNow;

  npc_ctrl u_ctrl (
    .periodStb(periodStb), .hystMode(hystMode), .satNow(satNow), .ctl(ctl)
  );

  npc_datapath #(.W(W), .VW(VW), .TW(TW), .CW(CW), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .refA(refA), .refB(refB), .refC(refC),
    .vUp(vUp), .vLo(vLo), .tzIn(tzIn), .kp(kp), .ki(ki),
    .satNow(satNow),
    .subHex(subHex), .centralVec(centralVec),
    .holdInnerOn(holdInnerOn), .holdOuterOff(holdOuterOff),
    .redA(redA), .redB(redB), .redC(redC),
    .tPos(tPos), .tNeg(tNeg), .coefF(coefF)
  );
endmodule

// File: rtl/npc_balancer_chk.sv
module npc_balancer_chk #(
  parameter int W    = 16,
  parameter int VW   = 16,
  parameter int TW   = 16,
  parameter int FRAC = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   periodStb,
  input logic                   hystMode,
  input logic [VW-1:0]          vUp,
  input logic [VW-1:0]          vLo,
  input logic [TW-1:0]          tzIn,
  input logic [2:0]             subHex,
  input logic [2:0]             centralVec,
  input logic [2:0]             holdInnerOn,
  input logic [2:0]             holdOuterOff,
  input logic signed [((W > VW) ? W : VW)+1:0] redA,
  input logic [TW-1:0]          tPos,
  input logic [TW-1:0]          tNeg,
  input logic signed [FRAC+1:0] coefF
);
  localparam int FW = FRAC + 2;
  localparam logic signed [FW-1:0] ONE_F = {2'b01, {FRAC{1'b0}}};

  p_dur_sum_r6: assert property (@(posedge clk) disable iff (!rstN)
    periodStb |=> ({1'b0, tPos} + {1'b0, tNeg}) == {1'b0, $past(tzIn)});

  p_coef_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (coefF <= ONE_F) && (coefF >= -ONE_F));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !periodStb |=> $stable(tPos) && $stable(coefF) && $stable(subHex) && $stable(redA));

  p_hyst_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (periodStb && hystMode && (vUp > vLo)) |=> (tNeg == '0) && (coefF == ONE_F));

  p_cv_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    (subHex != 3'd0) |-> (subHex <= 3'd6) &&
      (($countones(centralVec) == 1) || ($countones(centralVec) == 2)));

  p_fix_disjoint_r4: assert property (@(posedge clk) disable iff (!rstN)
    (holdInnerOn & holdOuterOff) == 3'b000);
endmodule

bind npc_balancer npc_balancer_chk #(.W(W), .VW(VW), .TW(TW), .FRAC(FRAC)) u_chk (
  .clk(clk), .rstN(rstN), .periodStb(periodStb), .hystMode(hystMode),
  .vUp(vUp), .vLo(vLo), .tzIn(tzIn), .subHex(subHex), .centralVec(centralVec),
  .holdInnerOn(holdInnerOn), .holdOuterOff(holdOuterOff), .redA(redA),
  .tPos(tPos), .tNeg(tNeg), .coefF(coefF)
);

// File: tb/tb_npc_balancer.sv
`timescale 1ns/1ps
module tb_npc_balancer;
  localparam int W = 16, VW = 16, TW = 16, CW = 16, FRAC = 12;
  localparam int RW = W + 2;
  localparam longint ONE = 4096;

  logic clk = 0;
  logic rstN = 0;
  logic periodStb = 0;
  logic hystMode = 0;
  logic signed [W-1:0] refA = 0, refB = 0, refC = 0;
  logic [VW-1:0] vUp = 0, vLo = 0;
  logic [TW-1:0] tzIn = 0;
  logic signed [CW-1:0] kp = 0, ki = 0;
  logic [2:0] subHex, centralVec, holdInnerOn, holdOuterOff;
  logic signed [RW-1:0] redA, redB, redC;
  logic [TW-1:0] tPos, tNeg;
  logic signed [FRAC+1:0] coefF;

  always #2.5 clk = ~clk;

  npc_balancer #(.W(W), .VW(VW), .TW(TW), .CW(CW), .FRAC(FRAC)) dut (
    .clk(clk), .rstN(rstN), .periodStb(periodStb), .hystMode(hystMode),
    .refA(refA), .refB(refB), .refC(refC), .vUp(vUp), .vLo(vLo),
    .tzIn(tzIn), .kp(kp), .ki(ki),
    .subHex(subHex), .centralVec(centralVec),
    .holdInnerOn(holdInnerOn), .holdOuterOff(holdOuterOff),
    .redA(redA), .redB(redB), .redC(redC),
    .tPos(tPos), .tNeg(tNeg), .coefF(coefF)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;
  longint mInteg = 0;
  longint eHex, eCv, eRed[3], eTPos, eTNeg, eF;

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint cvTab(input int n);
    case (n)
      1: return 4; 2: return 6; 3: return 2;
      4: return 3; 5: return 1; default: return 5;
    endcase
  endfunction

  // reference model of one strobe
  task automatic model();
    longint r[3], e, raw, iN, d, cen;
    int ones;
    bit sat;
    r[2] = refA; r[1] = refB; r[0] = refC;
    eHex = 1; eCv = 4;
    for (int n = 6; n >= 1; n--) begin
      bit ok = 1;
      for (int l = 0; l < 3; l++) begin
        if (cvTab(n)[l]) begin if (r[l] < 0) ok = 0; end
        else begin if (r[l] > 0) ok = 0; end
      end
      if (ok) begin eHex = n; eCv = cvTab(n); end
    end
    d = (longint'(vUp) + longint'(vLo)) / 6;
    ones = 0;
    for (int l = 0; l < 3; l++) ones += int'(eCv[l]);
    for (int l = 0; l < 3; l++) begin
      if (ones == 1) cen = eCv[l] ? 2*d : -d;
      else           cen = eCv[l] ? d : -2*d;
      eRed[l] = r[l] - cen;
    end
    e = longint'(vUp) - longint'(vLo);
    if (hystMode) begin
      eF = (e > 0) ? ONE : (e < 0) ? -ONE : 0;
    end else begin
      iN  = mInteg + longint'(ki) * e;
      raw = longint'(kp) * e + iN;
      sat = (raw > ONE) || (raw < -ONE);
      eF  = (raw > ONE) ? ONE : (raw < -ONE) ? -ONE : raw;
      if (!sat) mInteg = iN;
    end
    eTPos = ((ONE + eF) * longint'(tzIn)) >>> 13;
    eTNeg = longint'(tzIn) - eTPos;
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " R3 subHex"}, subHex, eHex);
    chk({tag, " R3 centralVec"}, centralVec, eCv);
    chk({tag, " R4 holdInnerOn"}, holdInnerOn, eCv);
    chk({tag, " R4 holdOuterOff"}, holdOuterOff, (~eCv) & 7);
    chk({tag, " R5 redA"}, redA, eRed[2]);
    chk({tag, " R5 redB"}, redB, eRed[1]);
    chk({tag, " R5 redC"}, redC, eRed[0]);
    chk({tag, " R6 tPos"}, tPos, eTPos);
    chk({tag, " R6 tNeg"}, tNeg, eTNeg);
    chk({tag, hystMode ? " R7 coefF" : " R8 coefF"}, coefF, eF);
    chk({tag, " R10 bound"}, longint'((coefF <= 4096) && (coefF >= -4096)), 1);
  endtask

  task automatic strobe(input string tag);
    @(negedge clk);
    periodStb = 1;
    model();
    @(negedge clk);
    periodStb = 0;
    checkAll(tag);
  endtask

  task automatic setRefs(input int a, input int b, input int c);
    refA = W'(a); refB = W'(b); refC = W'(c);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    mInteg = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    doReset();
    // R1 reset state
    chk("R1 subHex", subHex, 0);
    chk("R1 holdOuterOff", holdOuterOff, 0);
    chk("R1 tPos", tPos, 0);
    chk("R1 coefF", coefF, 0);
    chk("R1 redA", redA, 0);

    // R3/R5 each sub-hexagon and ties, hysteresis
    hystMode = 1; vUp = 600; vLo = 600; tzIn = 1000;
    setRefs(300, -100, -200);  strobe("S1");
    setRefs(200, 100, -300);   strobe("S2");
    setRefs(-100, 300, -200);  strobe("S3");
    setRefs(-300, 100, 200);   strobe("S4");
    setRefs(-100, -200, 300);  strobe("S5");
    setRefs(200, -300, 100);   strobe("S6");
    setRefs(100, 0, -100);     strobe("tie S1/S2");
    setRefs(0, 100, -100);     strobe("tie S2/S3");
    setRefs(0, 0, 0);          strobe("all zero");
    setRefs(5, 6, 7);          strobe("no match");

    // R7 hysteresis outcomes
    vUp = 610; vLo = 600; tzIn = 777; strobe("hyst up");
    vUp = 590;                        strobe("hyst down");

    // R2 hold without strobe
    @(negedge clk);
    setRefs(-5000, 4000, 1000); vUp = 100; vLo = 9000; tzIn = 12345; hystMode = 0;
    @(negedge clk); @(negedge clk);
    chk("R2 hold tPos", tPos, eTPos);
    chk("R2 hold subHex", subHex, eHex);
    chk("R2 hold redA", redA, eRed[2]);

    // R9 anti-windup directed
    doReset();
    hystMode = 0; vUp = 1010; vLo = 1000; tzIn = 4000;
    kp = 16'sd4096; ki = 16'sd100;
    strobe("R9 saturate");
    chk("R9 saturated coef", coefF, 4096);
    kp = 0; ki = 1; vUp = 1005;
    strobe("R9 after sat");
    chk("R9 integ not wound", coefF, 5);
    strobe("R9 accumulate");
    chk("R9 integ accumulates", coefF, 10);
    hystMode = 1; strobe("R9 hyst hold");
    hystMode = 0; vUp = 1000; strobe("R9 held");
    chk("R9 integ held in hyst", coefF, 10);

    // random mix
    for (int i = 0; i < 400; i++) begin
      setRefs(int'($urandom) % 32768, int'($urandom) % 32768, int'($urandom) % 32768);
      if ($urandom % 2) refA = -refA;
      if ($urandom % 2) refB = -refB;
      if ($urandom % 2) refC = -refC;
      hystMode = ($urandom % 3) == 0;
      vUp = VW'(30000 + $urandom % 64);
      vLo = VW'(30000 + $urandom % 64);
      if ($urandom % 8 == 0) vUp = VW'($urandom);
      tzIn = TW'($urandom);
      kp = CW'(int'($urandom % 401) - 200);
      ki = CW'(int'($urandom % 41) - 20);
      strobe("random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule